// File: doc/BRIEF.md
# CAN Payload Security Checksum Engine

This block protects selected CAN data frames with an 8-bit checksum placed in the frame's last data byte. A frame is presented as a descriptor beat, carrying the 11-bit identifier and the data length code, followed by its payload, one byte per valid beat. The engine folds the payload bytes into a CRC-8 one byte per clock, with no stalls. A small identifier table, loaded through a write port, decides whether a frame carries the checksum.

In check mode the whole payload is streamed in and the final byte is compared with the computed value. In insert mode only the bytes in front of the checksum position are streamed, and the engine returns the byte to be transmitted there. One cycle after the last byte is accepted, the verdict appears together with a single-cycle done pulse. An abort input drops a frame at any point.

Top module: `can_sec_crc8`

## Requirements
- R1: The checksum is a CRC-8 with generator 0x85 (x^8+x^7+x^2+1). The register starts at 0x00, shifts left MSB first and gets no final XOR. It covers payload bytes in transmission order, byte 0 first, up to the byte before the last. The payload F7 07 00 00 07 44 30 gives 0x70.
- R2: In check mode (`mode_insert`=0) a protected frame of length L streams L bytes. `pass` is 1 when byte L-1 equals the computed CRC, otherwise `fail` is 1. Never both.
- R3: In insert mode (`mode_insert`=1) a frame streams L-1 bytes. At done, `crc_out` carries the computed CRC, and `pass` and `fail` stay 0.
- R4: Lengths 6, 7 and 8 are handled. A length code above 8 is treated as 8.
- R5: The table has 16 entries, each holding an identifier and an enable bit, written through `tbl_wr_*`. A frame whose identifier matches an enabled entry is protected. Any other frame reports `not_prot`=1 with `pass`=`fail`=0, and `crc_out` still shows the computed CRC.
- R6: A frame with effective length below 2 reports `len_err`=1 and `crc_out`=0, with no pass, fail or not_prot. When such a frame streams no bytes at all (length 0 in either mode, or length 1 in insert mode), done follows the descriptor by one cycle.
- R7: `done` is a one-cycle pulse, high in the cycle after the last byte (or the byte-less descriptor) is accepted. `pass`, `fail`, `not_prot`, `len_err` and `crc_out` are valid only with `done` and are 0 otherwise.
- R8: `abort` returns the engine to idle: no done for the dropped frame, a byte presented in the same cycle is discarded, and the next frame starts from a cleared CRC.
- R9: A descriptor presented while a frame is in progress is ignored, and so is a payload byte presented while idle.
- R10: After reset all outputs are 0 and every table entry is disabled, so any frame reports `not_prot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Drop the current frame |
| mode_insert | input | 1 | Sampled with the descriptor: 1 insert, 0 check |
| hdr_valid | input | 1 | Descriptor beat valid |
| hdr_id | input | 11 | Frame identifier |
| hdr_len | input | 4 | Data length code |
| byte_valid | input | 1 | Payload byte valid |
| byte_data | input | 8 | Payload byte |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 4 | Table entry index |
| tbl_wr_id | input | 11 | Identifier written to the entry |
| tbl_wr_ena | input | 1 | Enable bit written to the entry |
| done | output | 1 | Result pulse |
| pass | output | 1 | Checksum matched |
| fail | output | 1 | Checksum mismatched |
| not_prot | output | 1 | Identifier not protected |
| len_err | output | 1 | Length below 2 |
| crc_out | output | 8 | Computed checksum |

## Verification
The hardest situations to reach are those where unrelated stimulus lands inside a frame: a descriptor arriving while bytes are still being folded, or an abort landing on the same beat as a payload byte. Both can silently corrupt the CRC state without any visible error in that frame. The bench places a foreign descriptor on the second payload beat of a protected frame, and pulses abort together with a byte partway through an 8-byte frame. It then sends a fresh frame whose expected checksum comes only from a cleared start value. Byte-less length-error frames sent back to back exercise the descriptor-to-done path.

// File: rtl/can_sec_pkg.sv
package can_sec_pkg;
   localparam int CAN_ID_W  = 11;
   localparam int CAN_LEN_W = 4;
   localparam int CRC_W     = 8;

   typedef struct packed {
      logic             pass;
      logic             fail;
      logic             unprot;
      logic             len_bad;
      logic [CRC_W-1:0] crc;
   } verdict_t;
endpackage

// File: rtl/crc8_byte_step.sv
module crc8_byte_step #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h85
) (
   input  logic [W-1:0] crc_in,
   input  logic [7:0]   data_in,
   output logic [W-1:0] crc_out
);
   // Direct (non-augmented) form: each data bit joins the register top bit.
   always_comb begin
      logic [W-1:0] r;
      logic         fb;
      r = crc_in;
      for (int i = 7; i >= 0; i--) begin
         fb = r[W-1] ^ data_in[i];
         r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      crc_out = r;
   end
endmodule

// File: rtl/sec_id_table.sv
module sec_id_table #(
   parameter int DEPTH = 16,
   parameter int ID_W  = 11,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ID_W-1:0]  wr_id,
   input  logic             wr_ena,
   input  logic [ID_W-1:0]  lk_id,
   output logic             lk_hit
);
   logic [DEPTH-1:0] match;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sec_id_table: DEPTH must be at least 1");
      end
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic            on_q;
         logic [ID_W-1:0] id_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               on_q <= 1'b0;
               id_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
               on_q <= wr_ena;
               id_q <= wr_id;
            end
         end
         assign match[e] = on_q && (id_q == lk_id);
      end
   endgenerate

   assign lk_hit = |match;

   assert_written_entry_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && wr_ena) && lk_id == $past(wr_id)) |-> lk_hit);
endmodule

// File: rtl/can_sec_crc8.sv
module can_sec_crc8
   import can_sec_pkg::*;
#(
   parameter int             ID_W      = CAN_ID_W,
   parameter int             LEN_W     = CAN_LEN_W,
   parameter int             MAX_BYTES = 8,
   parameter int             TBL_DEPTH = 16,
   parameter logic [CRC_W-1:0] POLY    = 8'h85,
   localparam int            TA_W      = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             mode_insert,
   input  logic             hdr_valid,
   input  logic [ID_W-1:0]  hdr_id,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   input  logic             tbl_wr_en,
   input  logic [TA_W-1:0]  tbl_wr_idx,
   input  logic [ID_W-1:0]  tbl_wr_id,
   input  logic             tbl_wr_ena,
   output logic             done,
   output logic             pass,
   output logic             fail,
   output logic             not_prot,
   output logic             len_err,
   output logic [CRC_W-1:0] crc_out
);
   generate
      if (MAX_BYTES < 2 || MAX_BYTES >= (1 << LEN_W)) begin : g_bad_len
         $error("can_sec_crc8: MAX_BYTES must lie in 2 .. 2**LEN_W-1");
      end
   endgenerate

   logic             tbl_hit;
   logic [LEN_W-1:0] len_cl, need_now;
   logic             busy_q, ins_q, hit_q, lerr_q;
   logic [LEN_W-1:0] need_q, idx_q;
   logic [CRC_W-1:0] crc_q, crc_stepped;
   logic             is_last, fold;
   logic             done_q;
   verdict_t         verdict_q, finish_v;

   sec_id_table #(.DEPTH(TBL_DEPTH), .ID_W(ID_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_id(tbl_wr_id), .wr_ena(tbl_wr_ena),
      .lk_id(hdr_id), .lk_hit(tbl_hit)
   );

   crc8_byte_step #(.W(CRC_W), .POLY(POLY)) u_step (
      .crc_in(crc_q), .data_in(byte_data), .crc_out(crc_stepped)
   );

   assign len_cl   = (hdr_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : hdr_len;
   assign need_now = mode_insert ? ((len_cl == '0) ? '0 : len_cl - LEN_W'(1)) : len_cl;
   assign is_last  = (idx_q == need_q - LEN_W'(1));
   assign fold     = ins_q || !is_last;

   always_comb begin
      finish_v.len_bad = lerr_q;
      finish_v.unprot  = !lerr_q && !hit_q;
      finish_v.pass    = !ins_q && !lerr_q && hit_q && (byte_data == crc_q);
      finish_v.fail    = !ins_q && !lerr_q && hit_q && (byte_data != crc_q);
      finish_v.crc     = lerr_q ? '0 : (ins_q ? crc_stepped : crc_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ins_q     <= 1'b0;
         hit_q     <= 1'b0;
         lerr_q    <= 1'b0;
         need_q    <= '0;
         idx_q     <= '0;
         crc_q     <= '0;
         done_q    <= 1'b0;
         verdict_q <= '0;
      end else begin
         done_q    <= 1'b0;
         verdict_q <= '0;
         if (abort) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            crc_q  <= '0;
         end else if (!busy_q) begin
            if (hdr_valid) begin
               ins_q  <= mode_insert;
               hit_q  <= tbl_hit;
               lerr_q <= (len_cl < LEN_W'(2));
               need_q <= need_now;
               idx_q  <= '0;
               crc_q  <= '0;
               if (need_now == '0) begin
                  done_q            <= 1'b1;
                  verdict_q.len_bad <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
               end
            end
         end else if (byte_valid) begin
            idx_q <= idx_q + LEN_W'(1);
            if (fold) crc_q <= crc_stepped;
            if (is_last) begin
               busy_q    <= 1'b0;
               done_q    <= 1'b1;
               verdict_q <= finish_v;
            end
         end
      end
   end

   assign done     = done_q;
   assign pass     = verdict_q.pass;
   assign fail     = verdict_q.fail;
   assign not_prot = verdict_q.unprot;
   assign len_err  = verdict_q.len_bad;
   assign crc_out  = verdict_q.crc;

   assert_flags_need_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !(pass || fail || not_prot || len_err || crc_out != '0));
   assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(hdr_valid || byte_valid));
   assert_single_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pass, fail, not_prot, len_err}) <= 1);
   assert_insert_no_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ins_q) |-> (!pass && !fail));
   assert_lenerr_zero_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (crc_out == '0));
   assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(abort) |-> !done);
endmodule

// File: tb/can_sec_crc8_tb_top.sv
module can_sec_crc8_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        abort = 1'b0, mode_insert = 1'b0, hdr_valid = 1'b0, byte_valid = 1'b0;
   logic [10:0] hdr_id = '0;
   logic [3:0]  hdr_len = '0;
   logic [7:0]  byte_data = '0;
   logic        tbl_wr_en = 1'b0, tbl_wr_ena = 1'b0;
   logic [3:0]  tbl_wr_idx = '0;
   logic [10:0] tbl_wr_id = '0;
   logic        done, pass, fail, not_prot, len_err;
   logic [7:0]  crc_out;

   int n_vec = 0;
   int n_bad = 0;
   logic [11:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   can_sec_crc8 dut_i (
      .clk(clk), .rst_n(rst_n), .abort(abort), .mode_insert(mode_insert),
      .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_len(hdr_len),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_id(tbl_wr_id), .tbl_wr_ena(tbl_wr_ena),
      .done(done), .pass(pass), .fail(fail), .not_prot(not_prot), .len_err(len_err), .crc_out(crc_out)
   );

   // Augmented bit-serial reference: message bits then eight zero bits.
   function automatic logic [7:0] ref_crc(input logic [63:0] pl, input int n);
      logic [7:0] r = 8'h00;
      logic       top;
      for (int k = 0; k < n + 1; k++) begin
         for (int b = 7; b >= 0; b--) begin
            top = r[7];
            r   = {r[6:0], (k < n) ? pl[8*k+b] : 1'b0};
            if (top) r = r ^ 8'h85;
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pop an expectation on each done pulse.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R7/R8/R9: unexpected done actual %h expected none",
                     {pass, fail, not_prot, len_err, crc_out});
         end else begin
            check(tag_q.pop_front(), {pass, fail, not_prot, len_err, crc_out}, exp_q.pop_front());
         end
      end
   end

   task automatic tbl_write(input int idx, input logic [10:0] id, input logic en);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 4'(idx); tbl_wr_id = id; tbl_wr_ena = en;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // Driver: push the expected verdict, then stream the frame.
   task automatic send_frame(input logic [10:0] id, input logic [3:0] dlc, input logic ins,
                             input logic [63:0] pl, input logic corrupt, input logic prot,
                             input string tag, input logic inj_hdr);
      int eff, nb;
      logic [7:0] c;
      logic le;
      logic [63:0] d;
      eff = (dlc > 8) ? 8 : int'(dlc);
      nb  = ins ? ((eff == 0) ? 0 : eff - 1) : eff;
      le  = (eff < 2);
      c   = le ? 8'h00 : ref_crc(pl, eff - 1);
      d   = pl;
      if (!le) d[8*(eff-1)+:8] = corrupt ? (c ^ 8'h01) : c;
      exp_q.push_back({!ins && !le && prot && !corrupt, !ins && !le && prot && corrupt,
                       !le && !prot, le, c});
      tag_q.push_back(tag);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_id = id; hdr_len = dlc; mode_insert = ins;
      @(negedge clk);
      hdr_valid = 1'b0; mode_insert = 1'b0;
      for (int k = 0; k < nb; k++) begin
         byte_valid = 1'b1; byte_data = d[8*k+:8];
         if (inj_hdr && k == 1) begin
            hdr_valid = 1'b1; hdr_id = 11'h284; hdr_len = 4'd3; mode_insert = 1'b1;
         end
         @(negedge clk);
         hdr_valid = 1'b0; mode_insert = 1'b0;
      end
      byte_valid = 1'b0;
   endtask

   localparam logic [63:0] VEC = 64'h00_30_44_07_00_00_07_F7;
   localparam logic [63:0] PA  = 64'h00_5A_13_C8_2E_91_4D_B6;
   localparam logic [63:0] PB  = 64'h00_01_FE_80_7F_33_CC_0A;

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset outputs", {done, pass, fail, not_prot, len_err, crc_out[6:0]},
            {done & 1'b0, 11'h000});
      // R10: empty table after reset -> not protected
      send_frame(11'h1D4, 4'd8, 1'b0, VEC, 1'b0, 1'b0, "R10 empty table", 1'b0);

      tbl_write(0, 11'h11A, 1'b1); tbl_write(1, 11'h1D4, 1'b1);
      tbl_write(2, 11'h1DA, 1'b1); tbl_write(3, 11'h1DB, 1'b1);
      tbl_write(4, 11'h1DC, 1'b1); tbl_write(5, 11'h55B, 1'b1);
      tbl_write(6, 11'h50C, 1'b1); tbl_write(15, 11'h1CB, 1'b1);
      tbl_write(8, 11'h1F2, 1'b0);

      check("R1 reference vector", {4'h0, ref_crc(VEC, 7)}, 12'h070);
      send_frame(11'h1D4, 4'd8, 1'b0, VEC, 1'b0, 1'b1, "R1 check vector", 1'b0);
      send_frame(11'h1D4, 4'd8, 1'b1, VEC, 1'b0, 1'b1, "R3 insert vector", 1'b0);
      send_frame(11'h1DA, 4'd8, 1'b0, PA, 1'b1, 1'b1, "R2 corrupted", 1'b0);
      send_frame(11'h55B, 4'd8, 1'b0, PB, 1'b0, 1'b1, "R2 match", 1'b0);
      send_frame(11'h50C, 4'd6, 1'b0, PA, 1'b0, 1'b1, "R4 len6", 1'b0);
      send_frame(11'h1CB, 4'd7, 1'b0, PB, 1'b0, 1'b1, "R4 len7", 1'b0);
      send_frame(11'h50C, 4'd6, 1'b1, PB, 1'b0, 1'b1, "R4 insert len6", 1'b0);
      send_frame(11'h1DB, 4'd12, 1'b0, PA, 1'b0, 1'b1, "R4 dlc12", 1'b0);
      send_frame(11'h1F2, 4'd8, 1'b0, PA, 1'b0, 1'b0, "R5 disabled entry", 1'b0);
      send_frame(11'h284, 4'd8, 1'b0, PB, 1'b0, 1'b0, "R5 miss", 1'b0);

      // R7: pulse timing
      send_frame(11'h1DC, 4'd8, 1'b0, PB, 1'b1, 1'b1, "R7 verdict", 1'b0);
      check("R7 done high after last byte", {11'h0, done}, 12'h001);
      @(negedge clk);
      check("R7 done one cycle", {11'h0, done}, 12'h000);

      // R6: length errors, back-to-back byte-less frames
      send_frame(11'h1D4, 4'd0, 1'b0, PA, 1'b0, 1'b1, "R6 len0 check", 1'b0);
      send_frame(11'h1D4, 4'd1, 1'b1, PA, 1'b0, 1'b1, "R6 len1 insert", 1'b0);
      send_frame(11'h1D4, 4'd1, 1'b0, PA, 1'b0, 1'b1, "R6 len1 check", 1'b0);

      // R8: abort mid-frame together with a byte
      @(negedge clk);
      hdr_valid = 1'b1; hdr_id = 11'h1D4; hdr_len = 4'd8;
      @(negedge clk);
      hdr_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         byte_valid = 1'b1; byte_data = 8'hA5 + 8'(k);
         abort = (k == 3);
         @(negedge clk);
      end
      byte_valid = 1'b0; abort = 1'b0;
      repeat (3) @(negedge clk);
      send_frame(11'h1D4, 4'd8, 1'b0, VEC, 1'b0, 1'b1, "R8 after abort", 1'b0);

      // R9: stray bytes while idle, descriptor during a frame
      byte_valid = 1'b1; byte_data = 8'hFF;
      repeat (2) @(negedge clk);
      byte_valid = 1'b0;
      send_frame(11'h11A, 4'd8, 1'b0, PA, 1'b0, 1'b1, "R9 idle bytes", 1'b0);
      send_frame(11'h1DA, 4'd7, 1'b0, PB, 1'b0, 1'b1, "R9 header in frame", 1'b1);

      // R5: disabling an entry removes protection
      tbl_write(0, 11'h11A, 1'b0);
      send_frame(11'h11A, 4'd8, 1'b0, PA, 1'b0, 1'b0, "R5 entry cleared", 1'b0);

      repeat (4) @(negedge clk);
      check("R7 all verdicts seen", {8'h0, 4'(exp_q.size())}, 12'h000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule